// File: doc/BRIEF.md
# Byte-Lane Strobe Controller for an Asynchronous 32-bit Static RAM

This block sits between a clocked host and an external asynchronous static RAM of 32768 words by 32 bits. The RAM's data bus is divided into four 8-bit lanes, and each lane has its own active-low chip select and write enable. All four lanes share one active-low output enable. The host issues one read or one write at a time through a valid/ready handshake. The block then drives the physical address, the lane strobes and the write data. For the required number of clock cycles it holds the strobes low, then releases them and raises a one-cycle completion pulse.

A width-mode input chooses how the host sees the storage. It can be 32K words of 32 bits, 64K half-words of 16 bits, or 128K bytes. In the narrow modes the low bits of the linear address choose the lane pair or the single lane, and the remaining bits become the 15-bit RAM address. Write data is replicated onto every lane so that whichever lanes are strobed receive it. Read data from the selected lanes is returned right-aligned and zero-extended. The strobe-low time is a whole number of clock cycles, obtained by rounding up the nanosecond minimums against the clock period. Reads and writes have separate minimums.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, all chip selects, write enables and the output enable are high (inactive), the data bus is not driven, `req_ready` is 1 and `done` is 0.
- R2: Width mode 2'b00 (32-bit) strobes all four lanes (`ram_cs_n` = 4'b0000), and the RAM address is linear address bits 14:0. Bits 16:15 are ignored.
- R3: Width mode 2'b01 (16-bit) strobes lanes 0 and 1 (`ram_cs_n` = 4'b1100) when linear bit 0 is 0, and lanes 2 and 3 (4'b0011) when it is 1. The RAM address is linear bits 15:1.
- R4: Width mode 2'b10 (8-bit) strobes only lane `addr[1:0]`, and the RAM address is linear bits 16:2. Mode 2'b11 behaves exactly like 2'b10.
- R5: During a write, the write enables are low on exactly the lanes whose chip select is low, the output enable stays high, and the data bus is driven from the first strobe cycle through the cycle after the strobes rise.
- R6: During a read, the write enables stay high and the output enable is low together with the chip selects. When `done` is high, `rd_data` holds the selected lanes right-aligned, with all higher bits zero.
- R7: The strobes stay low for exactly ceil(T_RD_PS/CLK_PS) cycles on a read and ceil(T_WP_PS/CLK_PS) cycles on a write. With the defaults these are 5 and 4 cycles.
- R8: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the cycle after `done`. `done` is high for exactly one cycle, in the first cycle with all strobes high. With no request, no strobe falls.
- R9: During a write, `ram_dq_out` carries the full word in 32-bit mode, the low half-word on both halves in 16-bit mode, and the low byte on all four lanes in 8-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Width mode: 00 32-bit, 01 16-bit, 10/11 8-bit |
| req_addr | input | 17 | Linear address |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Right-aligned, zero-extended read data |
| ram_addr | output | 15 | RAM word address |
| ram_cs_n | output | 4 | Per-lane chip select, active low |
| ram_we_n | output | 4 | Per-lane write enable, active low |
| ram_oe_n | output | 1 | Shared output enable, active low |
| ram_dq_out | output | 32 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Enable for driving `ram_dq_out` |
| ram_dq_in | input | 32 | Data read back from the RAM |

## Verification
Two events share one clock edge. The strobes are released in the same cycle that read data is captured and `done` rises, and the write-data drive overlaps the rising edge of the write enables. The sweep runs every width mode over many addresses, with a lane-accurate RAM model in the bench. The model places a filler value on unstrobed lanes, so any read value taken from the wrong lane, or not zero-extended, differs from the arithmetic expectation. At every sampled cycle the bench also checks that the data bus is still driven when the write enables are high again, and that `done` only appears once all strobes are high.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    typedef enum logic [1:0] {
        MODE_W32 = 2'b00,
        MODE_W16 = 2'b01,
        MODE_W8  = 2'b10,
        MODE_W8X = 2'b11
    } width_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_RELEASE
    } ctrl_state_e;
endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
    import sram_lane_pkg::*;
#(
    parameter int PA_W = 15
) (
    input  logic [1:0]      mode,
    input  logic [PA_W+1:0] lin_addr,
    output logic [PA_W-1:0] phys_addr,
    output logic [3:0]      lane_en,
    output logic [1:0]      lane_idx
);
    logic [3:0] single_lane;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_single
            assign single_lane[g] = (lin_addr[1:0] == 2'(g));
        end
    endgenerate

    always_comb begin
        case (mode)
            MODE_W32: begin
                phys_addr = lin_addr[PA_W-1:0];
                lane_en   = 4'b1111;
                lane_idx  = 2'd0;
            end
            MODE_W16: begin
                phys_addr = lin_addr[PA_W:1];
                lane_en   = lin_addr[0] ? 4'b1100 : 4'b0011;
                lane_idx  = {lin_addr[0], 1'b0};
            end
            default: begin
                phys_addr = lin_addr[PA_W+1:2];
                lane_en   = single_lane;
                lane_idx  = lin_addr[1:0];
            end
        endcase
    end
endmodule

// File: rtl/sram_lane_wsteer.sv
module sram_lane_wsteer
    import sram_lane_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    mode,
    input  logic [DW-1:0] wdata_in,
    output logic [DW-1:0] wdata_out
);
    localparam int LW = DW / 4;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_lane
            assign wdata_out[g*LW +: LW] =
                (mode == MODE_W32) ? wdata_in[g*LW +: LW] :
                (mode == MODE_W16) ? wdata_in[(g%2)*LW +: LW] :
                                     wdata_in[LW-1:0];
        end
    endgenerate
endmodule

// File: rtl/sram_lane_rpick.sv
module sram_lane_rpick
    import sram_lane_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    mode,
    input  logic [1:0]    lane_idx,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] picked
);
    localparam int LW = DW / 4;

    logic [DW-1:0] shifted;

    always_comb begin
        shifted = raw >> (int'(lane_idx) * LW);
        case (mode)
            MODE_W32: picked = raw;
            MODE_W16: picked = DW'(shifted[DW/2-1:0]);
            default:  picked = DW'(shifted[LW-1:0]);
        endcase
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int PA_W    = 15,
    parameter int DW      = 32,
    parameter int CLK_PS  = 4000,
    parameter int T_RD_PS = 20000,
    parameter int T_WP_PS = 13000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic [PA_W+1:0]   req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              done,
    output logic [DW-1:0]     rd_data,
    output logic [PA_W-1:0]   ram_addr,
    output logic [3:0]        ram_cs_n,
    output logic [3:0]        ram_we_n,
    output logic              ram_oe_n,
    output logic [DW-1:0]     ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DW-1:0]     ram_dq_in
);
    localparam int RD_CYC  = ((T_RD_PS + CLK_PS - 1) / CLK_PS) < 1 ? 1 : ((T_RD_PS + CLK_PS - 1) / CLK_PS);
    localparam int WR_CYC  = ((T_WP_PS + CLK_PS - 1) / CLK_PS) < 1 ? 1 : ((T_WP_PS + CLK_PS - 1) / CLK_PS);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int MIN_CYC = (RD_CYC < WR_CYC) ? RD_CYC : WR_CYC;

    typedef struct packed {
        ctrl_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [PA_W-1:0]  addr;
        logic [3:0]       cs_n;
        logic [3:0]       we_n;
        logic             oe_n;
        logic             dq_oe;
        logic [DW-1:0]    wdata;
        logic [1:0]       mode;
        logic [1:0]       lidx;
        logic             wr;
        logic             done;
        logic [DW-1:0]    rdata;
    } ctrl_regs_t;

    ctrl_regs_t regs_d, regs_q;

    logic [PA_W-1:0] map_phys;
    logic [3:0]      map_lanes;
    logic [1:0]      map_idx;
    logic [DW-1:0]   steered;
    logic [DW-1:0]   picked;

    sram_lane_map #(.PA_W(PA_W)) u_map (
        .mode      (req_mode),
        .lin_addr  (req_addr),
        .phys_addr (map_phys),
        .lane_en   (map_lanes),
        .lane_idx  (map_idx)
    );

    sram_lane_wsteer #(.DW(DW)) u_wsteer (
        .mode      (req_mode),
        .wdata_in  (req_wdata),
        .wdata_out (steered)
    );

    sram_lane_rpick #(.DW(DW)) u_rpick (
        .mode     (regs_q.mode),
        .lane_idx (regs_q.lidx),
        .raw      (ram_dq_in),
        .picked   (picked)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        case (regs_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.st    = ST_STROBE;
                    regs_d.addr  = map_phys;
                    regs_d.cs_n  = ~map_lanes;
                    regs_d.we_n  = req_write ? ~map_lanes : 4'hF;
                    regs_d.oe_n  = req_write;
                    regs_d.dq_oe = req_write;
                    regs_d.wdata = steered;
                    regs_d.mode  = req_mode;
                    regs_d.lidx  = map_idx;
                    regs_d.wr    = req_write;
                    regs_d.cnt   = req_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (regs_q.cnt == '0) begin
                    regs_d.st   = ST_RELEASE;
                    regs_d.cs_n = 4'hF;
                    regs_d.we_n = 4'hF;
                    regs_d.oe_n = 1'b1;
                    regs_d.done = 1'b1;
                    if (!regs_q.wr) begin
                        regs_d.rdata = picked;
                    end
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            default: begin
                regs_d.st    = ST_IDLE;
                regs_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.st    <= ST_IDLE;
            regs_q.cs_n  <= 4'hF;
            regs_q.we_n  <= 4'hF;
            regs_q.oe_n  <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready  = (regs_q.st == ST_IDLE);
    assign done       = regs_q.done;
    assign rd_data    = regs_q.rdata;
    assign ram_addr   = regs_q.addr;
    assign ram_cs_n   = regs_q.cs_n;
    assign ram_we_n   = regs_q.we_n;
    assign ram_oe_n   = regs_q.oe_n;
    assign ram_dq_out = regs_q.wdata;
    assign ram_dq_oe  = regs_q.dq_oe;
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
    parameter int MIN_LOW = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic [3:0] ram_cs_n,
    input logic [3:0] ram_we_n,
    input logic       ram_oe_n,
    input logic       ram_dq_oe
);
    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (ram_cs_n != 4'hF) begin
            low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
        end else begin
            low_run <= '0;
        end
    end

    // R5: a lane may only write while its chip select is low
    a_r5_we_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ram_we_n) & ram_cs_n) == 4'h0);

    // R5: output enable stays high whenever a write enable is low
    a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_n != 4'hF) |-> ram_oe_n);

    // R5: bus still driven in the cycle after the write enables rise
    a_r5_dq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_n != 4'hF) |=> ram_dq_oe);

    // R2: lanes strobed as one, a pair, or all four
    a_r2_lane_group: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ram_cs_n) != 3);

    // R7: the strobe-low run reaches the shorter of the two minimums
    a_r7_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs_n == 4'hF && low_run != 8'd0) |-> (low_run >= 8'(MIN_LOW)));

    // R8: completion pulse lasts one cycle
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion only with strobes released
    a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ram_cs_n == 4'hF && ram_we_n == 4'hF));

    // R8: an accepted request drops ready
    a_r8_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_lane_ctrl sram_lane_chk #(.MIN_LOW(MIN_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .ram_cs_n  (ram_cs_n),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
    localparam int EXP_RD = (20000 + 4000 - 1) / 4000;
    localparam int EXP_WR = (13000 + 4000 - 1) / 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [16:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rd_data;
    logic [14:0] ram_addr;
    logic [3:0]  ram_cs_n;
    logic [3:0]  ram_we_n;
    logic        ram_oe_n;
    logic [31:0] ram_dq_out;
    logic        ram_dq_oe;
    logic [31:0] ram_dq_in;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem  [0:255];
    logic [31:0] refm [0:255];

    always #2 clk = ~clk;

    sram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    // Lane-accurate RAM model; unselected lanes read as 8'hEE
    always_comb begin
        for (int g = 0; g < 4; g++) begin
            if (ram_oe_n)
                ram_dq_in[g*8 +: 8] = 8'h00;
            else if (!ram_cs_n[g])
                ram_dq_in[g*8 +: 8] = mem[ram_addr[7:0]][g*8 +: 8];
            else
                ram_dq_in[g*8 +: 8] = 8'hEE;
        end
    end

    always @(posedge clk) begin
        for (int g = 0; g < 4; g++) begin
            if (!ram_cs_n[g] && !ram_we_n[g] && ram_dq_oe)
                mem[ram_addr[7:0]][g*8 +: 8] <= ram_dq_out[g*8 +: 8];
        end
    end

    task automatic check(input logic cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] m, input logic [16:0] a);
        if (m == 2'b00) return 4'b1111;
        if (m == 2'b01) return a[0] ? 4'b1100 : 4'b0011;
        return 4'(1 << a[1:0]);
    endfunction

    function automatic logic [14:0] exp_phys(input logic [1:0] m, input logic [16:0] a);
        if (m == 2'b00) return a[14:0];
        if (m == 2'b01) return 15'(a >> 1);
        return 15'(a >> 2);
    endfunction

    function automatic logic [31:0] exp_repl(input logic [1:0] m, input logic [31:0] w);
        if (m == 2'b00) return w;
        if (m == 2'b01) return {w[15:0], w[15:0]};
        return {4{w[7:0]}};
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] m, input logic [16:0] a);
        logic [31:0] word;
        word = refm[exp_phys(m, a)[7:0]];
        if (m == 2'b00) return word;
        if (m == 2'b01) return {16'h0, a[0] ? word[31:16] : word[15:0]};
        return {24'h0, word[a[1:0]*8 +: 8]};
    endfunction

    task automatic ref_write(input logic [1:0] m, input logic [16:0] a, input logic [31:0] w);
        logic [7:0] idx;
        idx = exp_phys(m, a)[7:0];
        if (m == 2'b00) refm[idx] = w;
        else if (m == 2'b01) begin
            if (a[0]) refm[idx][31:16] = w[15:0];
            else      refm[idx][15:0]  = w[15:0];
        end else refm[idx][a[1:0]*8 +: 8] = w[7:0];
    endtask

    task automatic access(input logic wr, input logic [1:0] m, input logic [16:0] a, input logic [31:0] w);
        int low_cnt;
        int guard;
        string tag_map;
        tag_map = (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : "R4";
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mode = m; req_addr = a; req_wdata = w;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_wdata = 32'hDEAD_BEEF;
        low_cnt = 0;
        guard = 0;
        while (!done && guard < 40) begin
            check(!req_ready, "R8 ready low while busy", 32'(req_ready), 32'd0);
            if (ram_cs_n != 4'hF) begin
                low_cnt++;
                check(ram_cs_n == ~exp_mask(m, a), {tag_map, " lane strobes"}, 32'(ram_cs_n), 32'(~exp_mask(m, a)));
                check(ram_addr == exp_phys(m, a), {tag_map, " ram address"}, 32'(ram_addr), 32'(exp_phys(m, a)));
                if (wr) begin
                    check(ram_we_n == ram_cs_n && ram_oe_n && ram_dq_oe, "R5 write strobes",
                          {23'h0, ram_dq_oe, ram_oe_n, ram_we_n, 3'h0}, {23'h0, 1'b1, 1'b1, ram_cs_n, 3'h0});
                    check(ram_dq_out == exp_repl(m, w), "R9 write data lanes", ram_dq_out, exp_repl(m, w));
                end else begin
                    check(ram_we_n == 4'hF && !ram_oe_n && !ram_dq_oe, "R6 read strobes",
                          {26'h0, ram_dq_oe, ram_oe_n, ram_we_n}, {26'h0, 1'b0, 1'b0, 4'hF});
                end
            end
            guard++;
            @(negedge clk);
        end
        check(done, "R8 done seen", 32'(done), 32'd1);
        check(ram_cs_n == 4'hF && ram_we_n == 4'hF && ram_oe_n, "R8 strobes high at done",
              {23'h0, ram_oe_n, ram_we_n, ram_cs_n}, {23'h0, 1'b1, 4'hF, 4'hF});
        check(low_cnt == (wr ? EXP_WR : EXP_RD), "R7 strobe low cycles", 32'(low_cnt), 32'(wr ? EXP_WR : EXP_RD));
        if (wr) begin
            check(ram_dq_oe, "R5 data held after write", 32'(ram_dq_oe), 32'd1);
            ref_write(m, a, w);
        end else begin
            check(rd_data == exp_read(m, a), "R6 read data", rd_data, exp_read(m, a));
        end
        @(negedge clk);
        check(!done && req_ready && !ram_dq_oe, "R8 back to idle",
              {29'h0, done, req_ready, ram_dq_oe}, {29'h0, 1'b0, 1'b1, 1'b0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 32'h0;
            refm[i] = 32'h0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ram_cs_n == 4'hF && ram_we_n == 4'hF && ram_oe_n && !ram_dq_oe && req_ready && !done,
              "R1 reset state", {22'h0, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe},
              {22'h0, 4'hF, 4'hF, 1'b1, 1'b0});
        rst_n = 1'b1;
        // R8: no request means no strobe
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(ram_cs_n == 4'hF && req_ready, "R8 idle without request", 32'(ram_cs_n), 32'hF);
        end
        // R2: full-word writes; upper linear bits vary and must be ignored
        for (int i = 0; i < 32; i++)
            access(1'b1, 2'b00, {2'(i % 4), 15'(i)}, (32'(i) * 32'h0102_0408) ^ 32'hA55A_3CC3);
        // R3: half-word writes into words 32..39
        for (int i = 64; i < 80; i++)
            access(1'b1, 2'b01, 17'(i), 32'hFFFF_0000 | 32'(i * 16'h0911));
        // R4: byte writes into words 40..47, alternating the two 8-bit codes
        for (int i = 160; i < 192; i++)
            access(1'b1, (i % 2 == 0) ? 2'b10 : 2'b11, 17'(i), 32'h1234_5600 | 32'(i * 7));
        // Reads in every width
        for (int i = 0; i < 48; i++)
            access(1'b0, 2'b00, {2'(3 - i % 4), 15'(i)}, 32'h0);
        for (int i = 0; i < 96; i++)
            access(1'b0, 2'b01, 17'(i), 32'h0);
        for (int i = 0; i < 192; i++)
            access(1'b0, (i % 3 == 0) ? 2'b11 : 2'b10, 17'(i), 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule